// File: doc/BRIEF.md
# Control/Data Word Separator with Rate Buffer

This block sits between a framed 16-bit word source and a downstream collector. Each frame of the incoming stream carries two control words, marked by a control strobe, followed by two slots. Those slots hold either hit data words, marked by a data strobe, or filler. The block discards every control and filler word and stores only the hit data words in a FIFO. It tags each stored word with a first-word flag and a last-word flag, decoded from the leading control word of its frame.

Data enters at half the clock rate, two words in every four clock cycles. A read command drains the FIFO one word per clock cycle with no gaps. A burst stops once the final word of an event has gone out. A separate collect command raises a trigger of fixed length toward the source, and the block's clock is forwarded to the source alongside that trigger.

Top module: `wordsep_rate_buffer`

## Requirements
- R1: A word is written to the FIFO only in a cycle where `davIn` is 1 and `cavIn` is 0. A word presented with `cavIn` 1 is never stored, even when `davIn` is also 1.
- R2: A control word is the leading word of its frame when `cavIn` is 1 and `cavIn` was 0 in the previous cycle. If bits 13 and 12 of that word are both 1, every data word up to the next leading control word is tagged first. If only one of the two bits is 1, the words are not tagged.
- R3: The last flag follows the same rule as R2, using bits 11 and 10 of the leading control word.
- R4: A `collectCmd` pulse drives `trigOut` to 1 for exactly TRIG_CYCLES clock cycles (default 4), starting in the cycle after the pulse. `clkOut` always equals `clk`.
- R5: After `readCmd`, one stored word is removed per cycle while the FIFO is not empty. Each word appears on `dataOut`/`firstOut`/`lastOut` with `validOut` = 1 in the cycle after its removal. Words leave in arrival order, back to back.
- R6: A burst ends after the second data word of a last-tagged frame has been delivered. Any words still stored stay in the FIFO until the next `readCmd`.
- R7: A `readCmd` that arrives while the FIFO is empty stays pending and starts delivery as soon as data is stored. `validOut` stays 0 while there is nothing to deliver.
- R8: The FIFO holds DEPTH words (default 1024). A data word that arrives while the FIFO is full is dropped, and the stored words are unaffected.
- R9: A synchronous reset empties the FIFO, clears both flag registers and any pending or active read, and drives `validOut` and `trigOut` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| wordIn | input | 16 | Incoming framed word |
| cavIn | input | 1 | Control-word strobe |
| davIn | input | 1 | Data-word strobe |
| collectCmd | input | 1 | Pulse requesting a trigger to the source |
| readCmd | input | 1 | Pulse starting a read burst |
| clkOut | output | 1 | Clock forwarded to the source |
| trigOut | output | 1 | Trigger to the source |
| dataOut | output | 16 | Delivered hit data word |
| firstOut | output | 1 | First-word flag of the delivered word |
| lastOut | output | 1 | Last-word flag of the delivered word |
| validOut | output | 1 | Delivered word is valid |

## Verification
A wrong pointer or count shows up as out-of-order, duplicated or missing words. It appears on the first word of the next burst, because every delivered word is compared with a bench model in order. A stale flag register shows up as a wrong `firstOut`/`lastOut` on the first data word after the leading control word that should have reloaded it. A read state that is stuck active or stuck idle shows up within a few cycles as words that should have been held, or as a pending read that never delivers. A wrong full threshold shows up as a word count other than 1024 after an overfill.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
  // Flag bit positions inside the leading control word of a frame
  localparam int FIRST_BIT_HI = 13;
  localparam int FIRST_BIT_LO = 12;
  localparam int LAST_BIT_HI  = 11;
  localparam int LAST_BIT_LO  = 10;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic capture;  // leading control word: reload flag registers
    logic push;     // store wordIn with current flags
    logic pop;      // remove head entry and present it at the output
  } wsbStrobes_t;

  typedef enum logic {
    RD_IDLE   = 1'b0,
    RD_ACTIVE = 1'b1
  } rdState_t;
endpackage

// File: rtl/wsb_ctrl.sv
module wsb_ctrl
  import wsb_pkg::*;
#(
  parameter int TRIG_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cavIn,
  input  logic        davIn,
  input  logic        collectCmd,
  input  logic        readCmd,
  input  logic        fifoEmpty,
  input  logic        fifoFull,
  input  logic        headEnd,
  output wsbStrobes_t strobes,
  output logic        trigOut
);
  localparam int TW = $clog2(TRIG_CYCLES + 1);

  logic          prevCav;
  rdState_t      rdState;
  logic [TW-1:0] trigCnt;

  always_ff @(posedge clk) begin
    if (rst) prevCav <= 1'b0;
    else     prevCav <= cavIn;
  end

  always_comb begin
    strobes.capture = cavIn && !prevCav;
    strobes.push    = davIn && !cavIn && !fifoFull;
    strobes.pop     = (rdState == RD_ACTIVE) && !fifoEmpty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdState <= RD_IDLE;
    end else if (readCmd) begin
      rdState <= RD_ACTIVE;
    end else if (strobes.pop && headEnd) begin
      rdState <= RD_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trigCnt <= '0;
    end else if (collectCmd) begin
      trigCnt <= TW'(TRIG_CYCLES);
    end else if (trigCnt != '0) begin
      trigCnt <= trigCnt - 1'b1;
    end
  end

  assign trigOut = (trigCnt != '0);

  AST_CTRL_NEVER_STORED: assert property (@(posedge clk) disable iff (rst)
    cavIn |-> !strobes.push); // R1

  AST_TRIG_START: assert property (@(posedge clk) disable iff (rst)
    collectCmd |=> trigOut); // R4

  AST_IDLE_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    (strobes.pop && headEnd && !readCmd) |=> !strobes.pop); // R6
endmodule

// File: rtl/wsb_datapath.sv
module wsb_datapath
  import wsb_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] wordIn,
  input  wsbStrobes_t      strobes,
  output logic             fifoEmpty,
  output logic             fifoFull,
  output logic             headEnd,
  output logic [WIDTH-1:0] dataOut,
  output logic             firstOut,
  output logic             lastOut,
  output logic             validOut
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = WIDTH + 3;  // {end, first, last, data}

  logic          firstFlag, lastFlag, dataIdx;
  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic [EW-1:0] headEntry, newEntry;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  // Flag capture from the leading control word of a frame
  always_ff @(posedge clk) begin
    if (rst) begin
      firstFlag <= 1'b0;
      lastFlag  <= 1'b0;
      dataIdx   <= 1'b0;
    end else if (strobes.capture) begin
      firstFlag <= wordIn[FIRST_BIT_HI] && wordIn[FIRST_BIT_LO];
      lastFlag  <= wordIn[LAST_BIT_HI] && wordIn[LAST_BIT_LO];
      dataIdx   <= 1'b0;
    end else if (strobes.push) begin
      dataIdx   <= 1'b1;
    end
  end

  assign newEntry = {lastFlag && dataIdx, firstFlag, lastFlag, wordIn};

  always_ff @(posedge clk) begin
    if (strobes.push) mem[wrPtr] <= newEntry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobes.push) wrPtr <= nextPtr(wrPtr);
      if (strobes.pop)  rdPtr <= nextPtr(rdPtr);
      unique case ({strobes.push, strobes.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headEntry = mem[rdPtr];
  assign headEnd   = headEntry[EW-1];
  assign fifoEmpty = (count == '0);
  assign fifoFull  = (count == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      validOut <= 1'b0;
      dataOut  <= '0;
      firstOut <= 1'b0;
      lastOut  <= 1'b0;
    end else begin
      validOut <= strobes.pop;
      if (strobes.pop) begin
        dataOut  <= headEntry[WIDTH-1:0];
        lastOut  <= headEntry[WIDTH];
        firstOut <= headEntry[WIDTH+1];
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R8

  AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    strobes.pop |-> count != '0); // R7

  AST_VALID_AFTER_POP: assert property (@(posedge clk) disable iff (rst)
    validOut |-> $past(strobes.pop)); // R5

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (count == '0 && !validOut)); // R9
endmodule

// File: rtl/wordsep_rate_buffer.sv
module wordsep_rate_buffer
  import wsb_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int DEPTH       = 1024,
  parameter int TRIG_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] wordIn,
  input  logic             cavIn,
  input  logic             davIn,
  input  logic             collectCmd,
  input  logic             readCmd,
  output logic             clkOut,
  output logic             trigOut,
  output logic [WIDTH-1:0] dataOut,
  output logic             firstOut,
  output logic             lastOut,
  output logic             validOut
);
  wsbStrobes_t strobes;
  logic        fifoEmpty, fifoFull, headEnd;

  assign clkOut = clk;

  wsb_ctrl #(.TRIG_CYCLES(TRIG_CYCLES)) uCtrl (
    .clk        (clk),
    .rst        (rst),
    .cavIn      (cavIn),
    .davIn      (davIn),
    .collectCmd (collectCmd),
    .readCmd    (readCmd),
    .fifoEmpty  (fifoEmpty),
    .fifoFull   (fifoFull),
    .headEnd    (headEnd),
    .strobes    (strobes),
    .trigOut    (trigOut)
  );

  wsb_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uData (
    .clk       (clk),
    .rst       (rst),
    .wordIn    (wordIn),
    .strobes   (strobes),
    .fifoEmpty (fifoEmpty),
    .fifoFull  (fifoFull),
    .headEnd   (headEnd),
    .dataOut   (dataOut),
    .firstOut  (firstOut),
    .lastOut   (lastOut),
    .validOut  (validOut)
  );
endmodule

// File: tb/tb_wordsep_rate_buffer.sv
module tb_wordsep_rate_buffer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] wordIn = '0;
  logic        cavIn = 1'b0, davIn = 1'b0, collectCmd = 1'b0, readCmd = 1'b0;
  logic        clkOut, trigOut, firstOut, lastOut, validOut;
  logic [15:0] dataOut;

  wordsep_rate_buffer dut (
    .clk(clk), .rst(rst), .wordIn(wordIn), .cavIn(cavIn), .davIn(davIn),
    .collectCmd(collectCmd), .readCmd(readCmd), .clkOut(clkOut),
    .trigOut(trigOut), .dataOut(dataOut), .firstOut(firstOut),
    .lastOut(lastOut), .validOut(validOut)
  );

  always #4 clk = ~clk;  // 125 MHz

  int errors = 0, checks = 0;
  int cycle = 0, rxCount = 0, firstCyc = 0, lastCyc = 0, fillCount = 0;
  logic [17:0] expQ[$];
  logic        monitorOn = 1'b1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] packExp(input bit f, input bit l, input logic [15:0] d);
    return {f, l, d};
  endfunction

  always @(posedge clk) begin
    cycle++;
    if (cycle > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycle, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Output monitor: in-order comparison against the bench model (R2 R3 R5)
  always @(negedge clk) begin
    if (!rst && monitorOn && validOut) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5 unexpected word", int'({firstOut, lastOut, dataOut}), 0);
      end else begin
        logic [17:0] e;
        e = expQ.pop_front();
        check({firstOut, lastOut, dataOut} == e, "R2 R3 R5 word/flags",
              int'({firstOut, lastOut, dataOut}), int'(e));
      end
      if (rxCount == 0) firstCyc = cycle;
      lastCyc = cycle;
      rxCount++;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idleInputs();
    cavIn = 0; davIn = 0; wordIn = 16'($urandom);
  endtask

  // One frame: two control words, two data/filler slots
  task automatic sendFrame(input bit f, input bit l, input bit hasData,
                           input bit partial, input bit badSlot);
    logic [15:0] c0, d0, d1;
    logic [1:0]  fb, lb;
    fb = f ? 2'b11 : (partial ? 2'b10 : 2'b00);
    lb = l ? 2'b11 : (partial ? 2'b01 : 2'b00);
    c0 = (16'($urandom) & 16'hC3FF) | {2'b00, fb, lb, 10'd0};
    d0 = 16'($urandom); d1 = 16'($urandom);
    cavIn = 1; davIn = 0; wordIn = c0; tick();
    cavIn = 1; davIn = 0; wordIn = 16'($urandom); tick();
    cavIn = badSlot; davIn = hasData; wordIn = d0;
    if (hasData && !badSlot) begin
      if (fillCount < 1024) expQ.push_back(packExp(f, l, d0));
      fillCount++;
    end
    tick();
    cavIn = 0; davIn = hasData; wordIn = d1;
    if (hasData) begin
      if (fillCount < 1024) expQ.push_back(packExp(f, l, d1));
      fillCount++;
    end
    tick();
    idleInputs();
  endtask

  task automatic sendEvent(input int n, input bit withIdle);
    for (int i = 0; i < n; i++) begin
      if (withIdle && ($urandom % 3 == 0)) sendFrame(0, 0, 0, 0, 0);
      sendFrame(i == 0, i == n - 1, 1, ($urandom % 2) == 1, 0);
    end
  endtask

  task automatic pulseRead();
    readCmd = 1; tick(); readCmd = 0;
  endtask

  task automatic waitDrain(input int limit);
    for (int i = 0; i < limit; i++) begin
      if (expQ.size() == 0) break;
      tick();
    end
    repeat (3) tick();
  endtask

  task automatic quietCheck(input int n, input string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); if (validOut) seen++;
      @(posedge clk); #1;
    end
    check(seen == 0, tag, seen, 0);
  endtask

  initial begin
    int trigHigh;
    void'($urandom(32'h5eed_0042));
    repeat (3) tick();
    @(negedge clk);
    check(validOut == 0, "R9 reset validOut", validOut, 0);
    check(trigOut == 0, "R9 reset trigOut", trigOut, 0);
    @(posedge clk); #1; rst = 0; tick();

    // R4 trigger length and clock forwarding
    collectCmd = 1; tick(); collectCmd = 0;
    @(negedge clk);
    check(trigOut == 1, "R4 trigger starts", trigOut, 1);
    check(clkOut == clk, "R4 clkOut low phase", clkOut, clk);
    trigHigh = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); if (trigOut) trigHigh++;
    end
    check(trigHigh == 4, "R4 trigger length", trigHigh, 4);
    @(posedge clk); #1;
    check(clkOut == 1, "R4 clkOut high phase", clkOut, 1);

    // R7 read pending before data
    rxCount = 0; fillCount = 0;
    pulseRead();
    quietCheck(10, "R7 no output while empty");
    sendEvent(4, 0);
    waitDrain(200);
    check(rxCount == 8, "R7 pending read delivers", rxCount, 8);

    // R5 back-to-back burst with idle frames
    rxCount = 0; fillCount = 0;
    sendEvent(6, 1);
    pulseRead();
    waitDrain(200);
    check(rxCount == 12, "R5 burst count", rxCount, 12);
    check(lastCyc - firstCyc == 11, "R5 back-to-back span", lastCyc - firstCyc, 11);

    // R6 burst stops after end of event
    rxCount = 0; fillCount = 0;
    sendEvent(3, 0);
    sendEvent(2, 0);
    pulseRead();
    for (int i = 0; i < 100; i++) begin
      if (expQ.size() == 4) break;
      tick();
    end
    repeat (10) tick();
    check(rxCount == 6, "R6 burst ends at last frame", rxCount, 6);
    check(expQ.size() == 4, "R6 words held", expQ.size(), 4);
    pulseRead();
    waitDrain(100);
    check(rxCount == 10, "R6 second burst", rxCount, 10);

    // R1 word with both strobes is not stored
    rxCount = 0; fillCount = 0;
    sendFrame(1, 0, 1, 0, 1);
    sendFrame(0, 1, 1, 0, 0);
    pulseRead();
    waitDrain(100);
    check(rxCount == 3, "R1 control-marked word dropped", rxCount, 3);

    // Random events (R2 R3 R5 R6)
    for (int k = 0; k < 6; k++) begin
      int n;
      n = 2 + int'($urandom % 7);
      rxCount = 0; fillCount = 0;
      sendEvent(n, 1);
      pulseRead();
      waitDrain(400);
      check(rxCount == 2 * n, "R6 random event count", rxCount, 2 * n);
    end

    // R9 reset clears stored data and read state
    fillCount = 0;
    sendEvent(3, 0);
    rst = 1; tick(); tick(); rst = 0;
    expQ.delete();
    rxCount = 0; fillCount = 0;
    @(negedge clk);
    check(validOut == 0, "R9 validOut after reset", validOut, 0);
    @(posedge clk); #1;
    pulseRead();
    quietCheck(10, "R9 FIFO emptied by reset");
    sendEvent(2, 0);
    waitDrain(100);
    check(rxCount == 4, "R9 fresh event after reset", rxCount, 4);

    // R8 overfill: only DEPTH words kept
    rxCount = 0; fillCount = 0;
    for (int i = 0; i < 520; i++) sendFrame(0, 0, 1, 0, 0);
    pulseRead();
    waitDrain(3000);
    check(rxCount == 1024, "R8 capacity", rxCount, 1024);
    quietCheck(10, "R8 nothing beyond capacity");
    check(expQ.size() == 0, "R8 model drained", expQ.size(), 0);
    rst = 1; tick(); tick(); rst = 0; tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule